// File: doc/BRIEF.md
# Twin Butterfly Rounding Multiplier

This unit performs one integer butterfly step of a fixed-point transform. It takes two signed operands and one signed coefficient. It forms the sum and the difference of the operands and multiplies each by the coefficient. Each product is rounded to nearest, with halves rounded up, and arithmetically shifted right. Both results leave the block in the same cycle, as a primary result and a companion result.

The shift amount, the destination register number and the reserved-form bit are taken from a 32-bit instruction word. Bits of the word are numbered from the MSB, so word bit 0 is `instr[31]`. The companion result is tagged for the register one above the primary destination. The output stage is a single register with no backpressure. An issued legal operation therefore always produces a result exactly one cycle later. An issued operation in the reserved form raises an illegal flag instead.

Top module: `twin_bfly_round`

## Requirements
- R1: One cycle after a legal issue, `res_pri` equals round_shift(P), where P is the low XLEN bits of the signed product of c and the XLEN-bit wrapped sum a+b.
- R2: In the same cycle, `res_cmp` equals round_shift(Q), where Q is the low XLEN bits of the signed product of c and the XLEN-bit wrapped difference a-b.
- R3: For a shift amount n from 1 to 31, round_shift adds 2^(n-1) to the product with XLEN-bit wraparound before shifting. For example, 3 gives 2 and -3 gives -1 when n=1.
- R4: The shift by n is arithmetic. The n upper result bits are copies of the sign bit of the rounded product.
- R5: When n=0, no constant is added and the product passes through unchanged.
- R6: The instruction fields are read as follows: n from `instr[10:6]` (word bits 21-25), the destination from `instr[25:21]` (word bits 6-10), and the reserved-form bit from `instr[0]` (word bit 31).
- R7: Whenever `out_valid` is high, `dst_cmp` equals `dst_pri`+1 modulo 32, so destination 31 pairs with 0.
- R8: An issue with `instr[0]`=1 sets `illegal` one cycle later and keeps `out_valid` low. The result and destination outputs keep their earlier values.
- R9: `out_valid` rises exactly one cycle after a legal issue. Both `out_valid` and `illegal` are low one cycle after a cycle without an issue.
- R10: While reset is asserted, `out_valid` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Issue strobe for the operation on the inputs |
| instr | input | 32 | Instruction word holding shift, destination and reserved-form bit |
| op_a | input | XLEN | First signed operand |
| op_b | input | XLEN | Second signed operand |
| op_c | input | XLEN | Signed coefficient |
| out_valid | output | 1 | Results and destinations are valid |
| illegal | output | 1 | The previous issue used the reserved form |
| res_pri | output | XLEN | Rounded, shifted (a+b)*c |
| res_cmp | output | XLEN | Rounded, shifted (a-b)*c |
| dst_pri | output | 5 | Destination register for the primary result |
| dst_cmp | output | 5 | Destination register for the companion result |

## Verification
Every result, destination tag, valid bit and illegal flag is due exactly one clock edge after the issuing cycle. The bench drives an operation on a falling edge and drops the strobe on the next falling edge. It then reads all outputs at that falling edge, which lies after the single register has loaded. One more falling edge later it confirms that the valid and illegal outputs have cleared. For reserved-form issues, it also compares the data outputs with the results of the last legal operation.

// File: rtl/twin_bfly_pkg.sv
package twin_bfly_pkg;

  localparam int unsigned INSN_W  = 32;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned SHAMT_W = 5;

  // LSB index of each field inside instr[31:0]; word bit k is instr[31-k]
  localparam int unsigned DST_LSB = 21;
  localparam int unsigned SH_LSB  = 6;
  localparam int unsigned RC_BIT  = 0;

  typedef struct packed {
    logic [REG_W-1:0]   dst;
    logic [SHAMT_W-1:0] shamt;
    logic               rsvd;
  } bfly_fields_t;

endpackage

// File: rtl/bfly_decode.sv
module bfly_decode
  import twin_bfly_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output bfly_fields_t      fields
);

  logic unused_insn_bits;

  always_comb begin
    fields.dst   = instr[DST_LSB +: REG_W];
    fields.shamt = instr[SH_LSB +: SHAMT_W];
    fields.rsvd  = instr[RC_BIT];
  end

  assign unused_insn_bits = ^{instr[31:26], instr[20:11], instr[5:1]};

endmodule

// File: rtl/bfly_prod.sv
module bfly_prod #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]      op_a,
  input  logic [XLEN-1:0]      op_b,
  input  logic [XLEN-1:0]      op_c,
  output logic [1:0][XLEN-1:0] prod
);

  logic [XLEN-1:0] sum_w;
  logic [XLEN-1:0] dif_w;

  always_comb begin
    sum_w   = op_a + op_b;
    dif_w   = op_a - op_b;
    // the low half of the product is the same for signed and unsigned operands
    prod[0] = sum_w * op_c;
    prod[1] = dif_w * op_c;
  end

endmodule

// File: rtl/bfly_round_shift.sv
module bfly_round_shift #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned SHAMT_W = 5
) (
  input  logic [XLEN-1:0]    value,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [XLEN-1:0]    result
);

  localparam int unsigned LSH_W = $clog2(XLEN) + 2;
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0]  bias;
  logic [XLEN-1:0]  biased;
  logic [LSH_W-1:0] lsh;
  logic [XLEN-1:0]  rot;
  logic [XLEN-1:0]  keep;
  logic [XLEN-1:0]  fill;

  always_comb begin
    if (shamt == '0) begin
      bias = '0;
    end else begin
      bias = ONE << (shamt - SHAMT_W'(1));
    end
    biased = value + bias;
    lsh    = LSH_W'(XLEN) - LSH_W'(shamt);
    rot    = (biased >> shamt) | (biased << lsh);
    keep   = {XLEN{1'b1}} >> shamt;
    fill   = {XLEN{biased[XLEN-1]}} & ~keep;
    result = (rot & keep) | fill;
  end

endmodule

// File: rtl/twin_bfly_round.sv
module twin_bfly_round
  import twin_bfly_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic [XLEN-1:0]   op_c,
  output logic              out_valid,
  output logic              illegal,
  output logic [XLEN-1:0]   res_pri,
  output logic [XLEN-1:0]   res_cmp,
  output logic [4:0]        dst_pri,
  output logic [4:0]        dst_cmp
);

  localparam int unsigned LANES = 2;

  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  bfly_fields_t                fld;
  logic [LANES-1:0][XLEN-1:0]  prod;
  logic [LANES-1:0][XLEN-1:0]  rnd;

  bfly_decode u_dec (
    .instr  (instr),
    .fields (fld)
  );

  bfly_prod #(.XLEN(XLEN)) u_prod (
    .op_a (op_a),
    .op_b (op_b),
    .op_c (op_c),
    .prod (prod)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bfly_round_shift #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_rs (
      .value  (prod[g]),
      .shamt  (fld.shamt),
      .result (rnd[g])
    );
  end

  logic             vld_d, vld_q;
  logic             ill_d, ill_q;
  logic             ld_en;
  logic [XLEN-1:0]  pri_q, cmp_q;
  logic [REG_W-1:0] dst_q, dst_n1;

  always_comb begin
    vld_d  = in_valid & ~fld.rsvd;
    ill_d  = in_valid &  fld.rsvd;
    ld_en  = vld_d;
    dst_n1 = fld.dst + REG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
    end
  end

  logic [REG_W-1:0] dstc_q;

  always_ff @(posedge clk) begin
    if (ld_en) begin
      pri_q  <= rnd[0];
      cmp_q  <= rnd[1];
      dst_q  <= fld.dst;
      dstc_q <= dst_n1;
    end
  end

  assign out_valid = vld_q;
  assign illegal   = ill_q;
  assign res_pri   = pri_q;
  assign res_cmp   = cmp_q;
  assign dst_pri   = dst_q;
  assign dst_cmp   = dstc_q;

endmodule

// File: rtl/twin_bfly_round_chk.sv
module twin_bfly_round_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       in_valid,
  input logic       rsvd_in,
  input logic [4:0] dst_in,
  input logic       out_valid,
  input logic       illegal,
  input logic [4:0] dst_pri,
  input logic [4:0] dst_cmp
);

  p_issue_latency_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && !rsvd_in) |=> out_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_valid |=> (!out_valid && !illegal));

  p_reserved_form_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && rsvd_in) |=> (illegal && !out_valid));

  p_pair_dest_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid |-> (dst_cmp == dst_pri + 5'd1));

  p_dest_field_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && !rsvd_in) |=> (dst_pri == $past(dst_in)));

  p_excl_flags_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !(out_valid && illegal));

endmodule

bind twin_bfly_round twin_bfly_round_chk u_chk (
  .clk       (clk),
  .rst_sn    (rst_sync_n),
  .in_valid  (in_valid),
  .rsvd_in   (instr[0]),
  .dst_in    (instr[25:21]),
  .out_valid (out_valid),
  .illegal   (illegal),
  .dst_pri   (dst_pri),
  .dst_cmp   (dst_cmp)
);

// File: tb/twin_bfly_round_tb.sv
module twin_bfly_round_tb;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     instr;
  logic [XLEN-1:0] op_a, op_b, op_c;
  logic            out_valid, illegal;
  logic [XLEN-1:0] res_pri, res_cmp;
  logic [4:0]      dst_pri, dst_cmp;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  twin_bfly_round #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .out_valid(out_valid), .illegal(illegal),
    .res_pri(res_pri), .res_cmp(res_cmp),
    .dst_pri(dst_pri), .dst_cmp(dst_cmp)
  );

  function automatic logic [XLEN-1:0] ref_rs(input logic signed [XLEN-1:0] p,
                                            input int n);
    logic signed [XLEN-1:0] t;
    t = p;
    if (n > 0) t = t + (64'sd1 <<< (n - 1));
    return t >>> n;
  endfunction

  function automatic logic [XLEN-1:0] ref_mul(input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] c);
    logic signed [2*XLEN-1:0] f;
    f = $signed({{XLEN{x[XLEN-1]}}, x}) * $signed({{XLEN{c[XLEN-1]}}, c});
    return f[XLEN-1:0];
  endfunction

  task automatic chk(input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] sh,
                                     input logic rc);
    return {6'd4, rt, 5'd3, 5'd9, sh, 5'd17, rc};
  endfunction

  logic [XLEN-1:0] last_pri, last_cmp;
  logic [4:0]      last_dst;

  task automatic run_op(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                        input logic [XLEN-1:0] c, input logic [4:0] rt,
                        input logic [4:0] sh, input logic rc, input string tag);
    logic [XLEN-1:0] ep, ec;
    @(negedge clk);
    in_valid = 1'b1; instr = mk(rt, sh, rc); op_a = a; op_b = b; op_c = c;
    @(negedge clk);
    in_valid = 1'b0; instr = '0;
    if (rc) begin
      chk({"R8 illegal ", tag}, XLEN'(illegal), XLEN'(1));
      chk({"R8 no valid ", tag}, XLEN'(out_valid), XLEN'(0));
      chk({"R8 hold pri ", tag}, res_pri, last_pri);
      chk({"R8 hold cmp ", tag}, res_cmp, last_cmp);
      chk({"R8 hold dst ", tag}, XLEN'(dst_pri), XLEN'(last_dst));
    end else begin
      ep = ref_rs(ref_mul(a + b, c), int'(sh));
      ec = ref_rs(ref_mul(a - b, c), int'(sh));
      chk({"R9 valid ", tag}, XLEN'(out_valid), XLEN'(1));
      chk({"R1 pri ", tag}, res_pri, ep);
      chk({"R2 cmp ", tag}, res_cmp, ec);
      chk({"R6 dst ", tag}, XLEN'(dst_pri), XLEN'(rt));
      chk({"R7 pair ", tag}, XLEN'(dst_cmp), XLEN'(5'(rt + 5'd1)));
      last_pri = ep; last_cmp = ec; last_dst = rt;
    end
    @(negedge clk);
    chk({"R9 drop ", tag}, XLEN'({out_valid, illegal}), XLEN'(0));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned sd;
    sd = $urandom(32'h5eed_1234);
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; op_a = '0; op_b = '0; op_c = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset flags", XLEN'({out_valid, illegal}), XLEN'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 half rounds up: 3/2 -> 2, -3/2 -> -1 (b=0, c=1)
    run_op(64'd3, 64'd0, 64'd1, 5'd2, 5'd1, 1'b0, "r3_pos");
    chk("R3 pos half", res_pri, 64'd2);
    run_op(-64'sd3, 64'd0, 64'd1, 5'd4, 5'd1, 1'b0, "r3_neg");
    chk("R3 neg half", last_pri, -64'sd1);
    // R5 n=0 passthrough
    run_op(64'd7, 64'd5, -64'sd3, 5'd8, 5'd0, 1'b0, "r5_zero");
    chk("R5 passthru", last_pri, -64'sd36);
    // R4 sign fill with large shift
    run_op(-64'sd1000000, 64'd0, 64'd1 << 40, 5'd9, 5'd31, 1'b0, "r4_fill");
    // codec shift 14
    run_op(64'd100, 64'd23, 64'd11585, 5'd10, 5'd14, 1'b0, "n14");
    // wraparound of sum
    run_op(64'h7fff_ffff_ffff_ffff, 64'd1, 64'd3, 5'd12, 5'd3, 1'b0, "wrap");
    // R7 destination 31 pairs with 0
    run_op(64'd1, 64'd2, 64'd3, 5'd31, 5'd2, 1'b0, "r7_wrap");
    // R8 reserved form holds outputs
    run_op(64'd55, 64'd66, 64'd77, 5'd5, 5'd4, 1'b1, "r8_rsvd");

    for (int i = 0; i < 300; i++) begin
      logic [4:0] sh;
      logic       rc;
      case ($urandom_range(0, 5))
        0: sh = 5'd0;
        1: sh = 5'd31;
        2: sh = 5'd14;
        default: sh = 5'($urandom_range(0, 31));
      endcase
      rc = ($urandom_range(0, 9) == 0);
      run_op({$urandom, $urandom}, {$urandom, $urandom},
             {{32{1'b0}}, $urandom} - 64'h8000_0000,
             5'($urandom_range(0, 31)), sh, rc, "rand");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule